// File: doc/BRIEF.md
# External Interrupt Detector with Noise Filter

This block watches four external interrupt pins and turns them into prioritised interrupt requests for a CPU. Every pin is first resynchronised to the block clock through two flops. The clock is taken to be the instruction-cycle clock. Pins 0 and 1 can fire on a rising edge, a falling edge, a high level or a low level. Pins 2 and 3 can fire on a rising edge, a falling edge or on both edges. Pin 3 also passes through a digital noise filter. The filter samples at the full clock rate, at one sixteenth of it, or at one sixty-fourth of it, and it accepts a new level only after two consecutive samples agree.

Each pin owns a pending flag and an enable bit. The request output is raised while any enabled flag is set. The block presents the enabled pending source with the lowest vector address: 03h, 0Bh, 13h or 1Bh for pins 0 to 3. A CPU acknowledge clears the presented flag when that pin is edge-triggered. A level-triggered flag instead follows the pin. Pins 2 and 3 also send a one-cycle event pulse to an external timer on each qualified edge. The enabled flags of pins 0 and 1 drive a wake-up output for leaving a low-power hold state.

Top module: `xint_ctrl`

## Requirements
- R1: A pin change applied between clock edges sets the pending flag of an edge-triggered pin 0, 1 or 2 after exactly three rising clock edges, and not after two.
- R2: Pins 0 and 1 use a 2-bit mode field in `mode_cfg` at bits [2i+1:2i]. The codes are 00 = rising edge, 01 = falling edge, 10 = high level and 11 = low level. An edge of the wrong direction leaves the flag clear.
- R3: Pins 2 and 3 use the same field positions. The codes are 00 = rising edge and 01 = falling edge, and both 10 and 11 mean both edges.
- R4: The vector is 03h, 0Bh, 13h or 1Bh for pins 0, 1, 2 and 3. Among the enabled pending pins, the lowest-numbered pin is presented first.
- R5: `irq_req` is high exactly when some pending flag has its `irq_en` bit set. A flag of a disabled pin is kept and is requested as soon as the pin is enabled.
- R6: `irq_ack` clears the presented edge-triggered flag on the next edge. A level-triggered flag stays set while the level persists and clears within three edges after the level ends.
- R7: `filt_sel` selects the pin 3 sample rate: 00 = every cycle, 01 = every 16 cycles, 10 or 11 = every 64 cycles. A new level is accepted after two consecutive samples show it, so a 1-cycle pulse is rejected at 00 while a 3-cycle pulse is accepted.
- R8: At 01, a 10-cycle pulse is rejected and a 40-cycle pulse is accepted. At 10, a 40-cycle pulse is rejected and a 140-cycle pulse is accepted.
- R9: `tmr_evt[0]` and `tmr_evt[1]` give a one-cycle pulse on each qualified edge of pins 2 and 3, whatever the enable bits say.
- R10: `wake_req` is high exactly when pin 0 or pin 1 has its flag set and its enable bit set. Pins 2 and 3 never drive it.
- R11: After reset no flag is set: `irq_req`, `tmr_evt` and `wake_req` are 0 and `irq_vec` reads 00h while no request is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 4 | Raw external interrupt pins, bit i is pin i |
| mode_cfg | input | 8 | Per-pin detection mode, field i at [2i+1:2i] |
| filt_sel | input | 2 | Pin 3 noise filter sample-rate select |
| irq_en | input | 4 | Per-pin request enable |
| irq_ack | input | 1 | CPU acknowledge of the presented request |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector of the presented request, 00h when idle |
| tmr_evt | output | 2 | Event pulses for the timer, bit 0 from pin 2 and bit 1 from pin 3 |
| wake_req | output | 1 | Wake-up request from pins 0 and 1 |

## Verification
For an unfiltered pin, the flag and the event pulse are due three clock edges after a pin change: two edges for the synchroniser and one for the detector. The request and vector follow the flag in the same cycle. An acknowledge or an enable change shows after one edge, or at once for the enable. The bench drives every input on a falling edge and counts falling edges to sample. It checks that nothing has appeared one cycle early and that the result is present on the due cycle. Filtered results depend on the phase of the sample strobe. For those, the bench waits well past the worst-case acceptance window before it reads the flag.

// File: rtl/xint_pkg.sv
package xint_pkg;
    localparam int unsigned NUM_SRC  = 4;
    localparam int unsigned VEC_W    = 8;
    localparam logic [7:0]  VEC_BASE = 8'h03;
    localparam logic [7:0]  VEC_STEP = 8'h08;

    typedef enum logic [1:0] {
        MODE_RISE = 2'b00,
        MODE_FALL = 2'b01,
        MODE_ALTA = 2'b10,
        MODE_ALTB = 2'b11
    } xint_mode_e;

    typedef enum logic [1:0] {
        FSEL_FULL  = 2'b00,
        FSEL_MID   = 2'b01,
        FSEL_SLOW  = 2'b10,
        FSEL_SLOWB = 2'b11
    } xint_fsel_e;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/xint_filter.sv
module xint_filter
    import xint_pkg::*;
#(
    parameter int unsigned DIV_MID  = 16,
    parameter int unsigned DIV_SLOW = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       din,
    output logic       dout
);
    localparam int unsigned PW = $clog2(DIV_SLOW);
    localparam int unsigned MW = $clog2(DIV_MID);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic          hit;
        logic          lvl;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic     strobe;

    always_comb begin
        case (xint_fsel_e'(sel))
            FSEL_FULL: strobe = 1'b1;
            FSEL_MID:  strobe = (st_q.pre[MW-1:0] == '0);
            default:   strobe = (st_q.pre == '0);
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + 1'b1;
        if (strobe) begin
            if (din != st_q.lvl) begin
                if (st_q.hit) begin
                    st_d.lvl = din;
                    st_d.hit = 1'b0;
                end else begin
                    st_d.hit = 1'b1;
                end
            end else begin
                st_d.hit = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.lvl;
endmodule

// File: rtl/xint_chan.sv
module xint_chan
    import xint_pkg::*;
#(
    parameter bit LEVEL_OK = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig,
    input  logic [1:0] mode,
    input  logic       clr,
    output logic       pend,
    output logic       evt
);
    typedef struct packed {
        logic prev;
        logic pend;
        logic evt;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     rise, fall, hit, is_level;

    always_comb begin
        rise     = sig & ~st_q.prev;
        fall     = ~sig & st_q.prev;
        is_level = LEVEL_OK && mode[1];
        case (xint_mode_e'(mode))
            MODE_RISE: hit = rise;
            MODE_FALL: hit = fall;
            default:   hit = LEVEL_OK ? 1'b0 : (rise | fall);
        endcase

        st_d      = st_q;
        st_d.prev = sig;
        if (is_level) begin
            st_d.pend = mode[0] ? ~sig : sig;
            st_d.evt  = 1'b0;
        end else begin
            st_d.pend = (st_q.pend & ~clr) | hit;
            st_d.evt  = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign evt  = st_q.evt;
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int unsigned DIV_MID  = 16,
    parameter int unsigned DIV_SLOW = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ext_in,
    input  logic [2*NUM_SRC-1:0] mode_cfg,
    input  logic [1:0]         filt_sel,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               irq_ack,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [1:0]         tmr_evt,
    output logic               wake_req
);
    localparam int unsigned SEL_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] sync_w, sig_w, pend_w, evt_w, clr_w, act_w;
    logic               filt3_w, any_w;
    logic [SEL_W-1:0]   sel_w;

    xint_sync #(.W(NUM_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_in), .dout(sync_w)
    );

    xint_filter #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_filt (
        .clk(clk), .rst_n(rst_n), .sel(filt_sel),
        .din(sync_w[NUM_SRC-1]), .dout(filt3_w)
    );

    assign sig_w = {filt3_w, sync_w[NUM_SRC-2:0]};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chan
        xint_chan #(.LEVEL_OK(i < 2)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .sig  (sig_w[i]),
            .mode (mode_cfg[2*i+1:2*i]),
            .clr  (clr_w[i]),
            .pend (pend_w[i]),
            .evt  (evt_w[i])
        );
    end

    always_comb begin
        act_w = pend_w & irq_en;
        any_w = |act_w;
        sel_w = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (act_w[i]) sel_w = SEL_W'(i);
        end
        clr_w   = (irq_ack && any_w) ? (NUM_SRC'(1) << sel_w) : '0;
        irq_vec = any_w ? (VEC_BASE + VEC_STEP * VEC_W'(sel_w)) : '0;
    end

    assign irq_req  = any_w;
    assign tmr_evt  = evt_w[NUM_SRC-1:NUM_SRC-2];
    assign wake_req = |act_w[1:0];
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_req,
    input logic [7:0] irq_vec,
    input logic       irq_en0,
    input logic       irq_ack,
    input logic [1:0] tmr_evt,
    input logic       wake_req,
    input logic [3:0] pend,
    input logic       evt0,
    input logic       evt1,
    input logic       evt3,
    input logic       sync0,
    input logic [1:0] mode0
);
    // R4: vectors sit at 8-byte steps from 03h
    p_vec_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec[7:5] == 3'b000));

    // R4: enabled pin 0 always wins
    p_vec_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && irq_en0) |-> (irq_vec == 8'h03));

    // R11: idle vector reads zero
    p_idle_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == 8'h00));

    // R6: acknowledged pin 3 flag clears unless a new edge arrives
    p_ack_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_vec == 8'h1B) |=> (!pend[3] || evt3));

    // R6: held high level keeps pin 0 pending
    p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 2'b10 && sync0) ##1 (mode0 == 2'b10) |-> pend[0]);

    // R2: a qualified edge on pins 0 and 1 lands in the flag
    p_edge_sets_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt0 |-> pend[0]) and (evt1 |-> pend[1]));

    // R9: pin 2 event coincides with its flag, filtered pin 3 pulses are single
    p_evt2_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt[0] |-> pend[2]);
    p_evt3_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt[1] |=> !tmr_evt[1]);

    // R10: wake implies a request
    p_wake_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> irq_req);
endmodule

bind xint_ctrl xint_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .irq_en0 (irq_en[0]),
    .irq_ack (irq_ack),
    .tmr_evt (tmr_evt),
    .wake_req(wake_req),
    .pend    (pend_w),
    .evt0    (evt_w[0]),
    .evt1    (evt_w[1]),
    .evt3    (evt_w[3]),
    .sync0   (sync_w[0]),
    .mode0   (mode_cfg[1:0])
);

// File: tb/xint_ctrl_bench.sv
`timescale 1ns/1ps
module xint_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ext_in = '0;
    logic [7:0] mode_cfg = '0;
    logic [1:0] filt_sel = '0;
    logic [3:0] irq_en = '0;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic [1:0] tmr_evt;
    logic       wake_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xint_ctrl u_xint_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .mode_cfg(mode_cfg),
        .filt_sel(filt_sel), .irq_en(irq_en), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vec(irq_vec), .tmr_evt(tmr_evt),
        .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
    endtask

    task automatic drain();
        ext_in   = '0;
        mode_cfg = '0;
        irq_en   = 4'hF;
        step(5);
        for (int k = 0; k < 8; k++) begin
            if (irq_req) ack_once();
        end
        irq_en = '0;
        step(1);
    endtask

    task automatic t_reset();
        chk("R11 irq_req after reset", irq_req, 0);
        chk("R11 irq_vec after reset", irq_vec, 8'h00);
        chk("R11 tmr_evt after reset", tmr_evt, 0);
        chk("R11 wake_req after reset", wake_req, 0);
    endtask

    task automatic t_latency();
        irq_en = 4'b0001;
        ext_in[0] = 1'b1;
        step(2);
        chk("R1 no flag after two edges", irq_req, 0);
        step(1);
        chk("R1 flag after three edges", irq_req, 1);
        chk("R1 vector pin 0", irq_vec, 8'h03);
        ack_once();
        chk("R6 edge flag cleared by ack", irq_req, 0);
        drain();
    endtask

    task automatic t_modes01();
        irq_en = 4'b0010;
        mode_cfg[3:2] = 2'b01;
        ext_in[1] = 1'b1;
        step(5);
        chk("R2 falling mode ignores rise", irq_req, 0);
        ext_in[1] = 1'b0;
        step(3);
        chk("R2 falling mode catches fall", irq_req, 1);
        chk("R4 vector pin 1", irq_vec, 8'h0B);
        ack_once();
        mode_cfg[3:2] = 2'b10;
        ext_in[1] = 1'b1;
        step(3);
        chk("R2 high level pending", irq_req, 1);
        ack_once();
        chk("R6 level flag survives ack", irq_req, 1);
        ext_in[1] = 1'b0;
        step(3);
        chk("R6 level flag drops with level", irq_req, 0);
        mode_cfg[3:2] = 2'b11;
        step(2);
        chk("R2 low level pending", irq_req, 1);
        ext_in[1] = 1'b1;
        step(3);
        chk("R2 low level released", irq_req, 0);
        drain();
    endtask

    task automatic t_modes23();
        irq_en = 4'b0100;
        mode_cfg[5:4] = 2'b10;
        ext_in[2] = 1'b1;
        step(3);
        chk("R9 event on rise in both mode", tmr_evt, 2'b01);
        chk("R3 both mode flags rise", irq_vec, 8'h13);
        step(1);
        chk("R9 event lasts one cycle", tmr_evt, 2'b00);
        ack_once();
        chk("R6 pin 2 ack clears", irq_req, 0);
        ext_in[2] = 1'b0;
        step(3);
        chk("R3 both mode flags fall", irq_req, 1);
        drain();
        mode_cfg[5:4] = 2'b01;
        ext_in[2] = 1'b1;
        irq_en = 4'b0000;
        step(3);
        chk("R9 no event on rise in falling mode", tmr_evt, 2'b00);
        ext_in[2] = 1'b0;
        step(3);
        chk("R9 event without enable", tmr_evt, 2'b01);
        chk("R5 disabled pin not requested", irq_req, 0);
        drain();
    endtask

    task automatic t_priority();
        irq_en = 4'hF;
        ext_in = 4'b1110;
        step(10);
        chk("R4 lowest vector first", irq_vec, 8'h0B);
        ack_once();
        chk("R4 next vector", irq_vec, 8'h13);
        ack_once();
        chk("R4 last vector", irq_vec, 8'h1B);
        ack_once();
        chk("R4 all served", irq_req, 0);
        drain();
    endtask

    task automatic t_enable_wake();
        irq_en = 4'b0000;
        ext_in[0] = 1'b1;
        step(5);
        chk("R5 masked flag gives no request", irq_req, 0);
        chk("R10 masked flag gives no wake", wake_req, 0);
        irq_en = 4'b0001;
        step(1);
        chk("R5 kept flag requested on enable", irq_vec, 8'h03);
        chk("R10 wake from pin 0", wake_req, 1);
        drain();
        irq_en = 4'b0100;
        ext_in[2] = 1'b1;
        step(4);
        chk("R10 pin 2 request", irq_req, 1);
        chk("R10 pin 2 gives no wake", wake_req, 0);
        drain();
    endtask

    task automatic pulse3(input int w);
        ext_in[3] = 1'b1;
        step(w);
        ext_in[3] = 1'b0;
    endtask

    task automatic t_filter();
        irq_en = 4'b1000;
        filt_sel = 2'b00;
        pulse3(1);
        step(12);
        chk("R7 1-cycle pulse rejected", irq_req, 0);
        pulse3(3);
        step(10);
        chk("R7 3-cycle pulse accepted", irq_vec, 8'h1B);
        drain();
        irq_en = 4'b1000;
        filt_sel = 2'b01;
        pulse3(10);
        step(100);
        chk("R8 10-cycle pulse rejected at 1/16", irq_req, 0);
        pulse3(40);
        step(100);
        chk("R8 40-cycle pulse accepted at 1/16", irq_req, 1);
        drain();
        irq_en = 4'b1000;
        filt_sel = 2'b10;
        pulse3(40);
        step(300);
        chk("R8 40-cycle pulse rejected at 1/64", irq_req, 0);
        pulse3(140);
        step(300);
        chk("R8 140-cycle pulse accepted at 1/64", irq_req, 1);
        drain();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_latency();
        t_modes01();
        t_modes23();
        t_priority();
        t_enable_wake();
        t_filter();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule